// File: doc/BRIEF.md
# Paced UART Transmit Queue

This block sits between a host register interface and a UART transmit shift register. In queued mode, the host writes bytes into a 16-deep, 8-bit first-in first-out store. The block hands those bytes to the shifter one at a time. After each hand-over it waits a programmable number of baud ticks, from 0 to 255, before it offers the next byte. This lets a slow receiver keep pace without help from software. The block reports how many bytes are waiting. It raises a level interrupt while that count is at or below a programmable trigger level.

A run control clears the queue while it is low, and operation restarts from empty once the control returns high. When queued mode is off, host writes pass straight through to the shifter load path and the queue is held empty.

The shifter and the baud generator are outside the block. The shifter returns a single "empty" level. After a load, the block waits until that level has dropped and risen again before it issues the next load.

Top module: `uart_tx_pacer`

## Requirements
- R1: Out of reset `fill_o` is 0, `ovf_o` is 0, and `load_o` is 0 while no write is presented.
- R2: In queued mode, each accepted write raises `fill_o` by one at the next clock edge, up to 16. Bytes reach `load_data_o` in the order they were written.
- R3: A write that finds 16 bytes stored is discarded. `fill_o` stays 16, and `ovf_o` is high for exactly the one cycle after that write's clock edge.
- R4: In queued mode, `load_o` is high only when all of the following hold:
  - the queue is non-empty;
  - `shf_empty_i` is high;
  - the gap has expired;
  - `shf_empty_i` has been seen low since the previous load.

  Each load removes one byte.
- R5: With a gap value G > 0 on `gap_i` at a load, no further load occurs until G `baud_tick_i` pulses have been seen at later clock edges. With the shifter idle, the next load follows one cycle after the G-th tick.
- R6: With G = 0, the next load is asserted in the first cycle in which the shifter reports empty again after having gone busy.
- R7: `irq_o` is high exactly when queued mode is on and `fill_o` is less than or equal to `trig_lvl_i`. A trigger level of 0 gives an interrupt only on empty.
- R8: While `fifo_run_i` is 0, `fill_o` reads 0 from the next edge on, writes are discarded and nothing is loaded. After `fifo_run_i` returns to 1, the first byte written is the first byte loaded.
- R9: While `fifo_en_i` is 0, `load_o` equals `wr_valid_i` and `load_data_o` equals `wr_data_i` in the same cycle. The queue is held empty, `fill_o` is 0 and `irq_o` is 0. Bytes queued before queued mode was switched off are never loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_en_i | input | 1 | 1 = queued mode, 0 = direct pass-through |
| fifo_run_i | input | 1 | 0 clears and holds the queue empty |
| wr_valid_i | input | 1 | Host write strobe |
| wr_data_i | input | 8 | Host write byte |
| gap_i | input | 8 | Baud ticks to wait after each load |
| trig_lvl_i | input | 5 | Interrupt trigger level |
| baud_tick_i | input | 1 | One-cycle baud clock tick |
| shf_empty_i | input | 1 | Shifter has finished and can accept a byte |
| load_o | output | 1 | Shifter load strobe |
| load_data_o | output | 8 | Byte to load |
| fill_o | output | 5 | Bytes currently queued, 0..16 |
| irq_o | output | 1 | Level interrupt, fill at or below trigger |
| ovf_o | output | 1 | One-cycle pulse after a discarded write |

## Verification
The fill count and the overflow pulse are registered, so the bench checks them at the falling edge that follows the write's rising edge. `load_o` and the pass-through path are combinational and are checked within the same cycle as their cause. The bench shifter model keeps the shifter busy for three cycles after each load, so with zero gap the loads are exactly four cycles apart. With a non-zero gap, the number of ticks between loads must equal the gap value, because ticks arrive every four cycles and never on a load edge. Loads are logged at rising edges together with their cycle distance and tick count, and the checks read that log after the queue has drained.

// File: rtl/uart_txq_pkg.sv
package uart_txq_pkg;
  localparam int unsigned TXQ_DEPTH = 16;
  localparam int unsigned TXQ_DW    = 8;
  localparam int unsigned TXQ_GAP_W = 8;
endpackage

// File: rtl/uart_txq_store.sv
module uart_txq_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          ovf_q;
  logic          full, push_ok, pop_ok;

  assign full    = (cnt_q == FULL);
  assign push_ok = push_i && !full && !clr_i;
  assign pop_ok  = pop_i && (cnt_q != '0) && !clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (push_ok) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
      ovf_q <= push_i && full;  // write against a full queue is dropped
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= wdata_i;
  end

  assign rdata_o = mem_q[rp_q];
  assign cnt_o   = cnt_q;
  assign ovf_o   = ovf_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= FULL);
  p_full_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full && !pop_i && !clr_i) |=> (cnt_q == FULL) && ovf_o);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0) && !ovf_o);
endmodule

// File: rtl/uart_txq_pacer.sv
module uart_txq_pacer #(
  parameter int unsigned GAP_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             avail_i,
  input  logic             shf_empty_i,
  input  logic             tick_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             pop_o
);
  logic [GAP_W-1:0] gap_q;
  logic             pend_q;  // load issued, shifter not yet seen busy

  assign pop_o = !clr_i && avail_i && shf_empty_i && !pend_q && (gap_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      gap_q  <= '0;
      pend_q <= 1'b0;
    end else if (pop_o) begin
      gap_q  <= gap_i;
      pend_q <= 1'b1;
    end else begin
      if (tick_i && gap_q != '0) gap_q <= gap_q - 1'b1;
      if (!shf_empty_i)          pend_q <= 1'b0;
    end
  end

  p_one_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !pop_o);
  p_gap_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_o && gap_i != '0 && !clr_i) |=> !pop_o && !clr_i |=> !pop_o);
endmodule

// File: rtl/uart_tx_pacer.sv
module uart_tx_pacer
  import uart_txq_pkg::*;
#(
  parameter int unsigned DEPTH = TXQ_DEPTH,
  parameter int unsigned DW    = TXQ_DW,
  parameter int unsigned GAP_W = TXQ_GAP_W,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic             fifo_run_i,
  input  logic             wr_valid_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [GAP_W-1:0] gap_i,
  input  logic [CW-1:0]    trig_lvl_i,
  input  logic             baud_tick_i,
  input  logic             shf_empty_i,
  output logic             load_o,
  output logic [DW-1:0]    load_data_o,
  output logic [CW-1:0]    fill_o,
  output logic             irq_o,
  output logic             ovf_o
);
  logic          clr, pop;
  logic [DW-1:0] q_data;
  logic [CW-1:0] cnt;

  // queue held empty outside queued mode or while run is low
  assign clr = !fifo_en_i || !fifo_run_i;

  uart_txq_store #(.DEPTH(DEPTH), .DW(DW)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .push_i  (fifo_en_i && wr_valid_i),
    .pop_i   (pop),
    .wdata_i (wr_data_i),
    .rdata_o (q_data),
    .cnt_o   (cnt),
    .ovf_o   (ovf_o)
  );

  uart_txq_pacer #(.GAP_W(GAP_W)) i_pacer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .avail_i     (cnt != '0),
    .shf_empty_i (shf_empty_i),
    .tick_i      (baud_tick_i),
    .gap_i       (gap_i),
    .pop_o       (pop)
  );

  assign load_o      = fifo_en_i ? pop : wr_valid_i;
  assign load_data_o = fifo_en_i ? q_data : wr_data_i;
  assign fill_o      = cnt;
  assign irq_o       = fifo_en_i && (cnt <= trig_lvl_i);

  p_load_needs_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_en_i && load_o) |-> (fill_o != '0) && shf_empty_i && fifo_run_i);
  p_bypass_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |=> (fill_o == '0));
endmodule

// File: tb/test_uart_tx_pacer.sv
module test_uart_tx_pacer;
  logic       clk = 0, rst_n = 0;
  logic       fifo_en = 0, fifo_run = 0, wr_valid = 0, baud_tick = 0;
  logic [7:0] wr_data = 0, gap = 0, load_data;
  logic [4:0] trig = 0, fill;
  logic       load, irq, ovf, shf_empty, hold = 1, tick_en = 0;

  int n_chk = 0, n_fail = 0, busy = 0, cyc = 0, last_cyc = 0, ticks = 0, tcnt = 0;
  logic [7:0] log_data [64];
  int log_ticks [64];
  int log_cyc [64];
  int n_log = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_tx_pacer i_uart_tx_pacer (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .fifo_run_i(fifo_run),
    .wr_valid_i(wr_valid), .wr_data_i(wr_data), .gap_i(gap), .trig_lvl_i(trig),
    .baud_tick_i(baud_tick), .shf_empty_i(shf_empty), .load_o(load),
    .load_data_o(load_data), .fill_o(fill), .irq_o(irq), .ovf_o(ovf));

  // shifter model: busy three cycles after each load
  assign shf_empty = (busy == 0) && !hold;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (load) begin
      busy <= 3;
      if (n_log < 64) begin
        log_data[n_log]  = load_data;
        log_ticks[n_log] = ticks;
        log_cyc[n_log]   = cyc - last_cyc;
      end
      n_log = n_log + 1;
      last_cyc <= cyc;
      ticks <= 0;
    end else begin
      if (busy > 0) busy <= busy - 1;
      if (baud_tick) ticks <= ticks + 1;
    end
  end

  always @(negedge clk) begin
    if (tick_en) begin
      tcnt <= tcnt + 1;
      baud_tick <= (tcnt % 4 == 3);
    end else baud_tick <= 0;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    @(negedge clk); wr_valid = 1; wr_data = d;
    @(negedge clk); wr_valid = 0;
  endtask

  task automatic restart;
    @(negedge clk); fifo_run = 0; hold = 1;
    @(negedge clk); fifo_run = 1; n_log = 0;
  endtask

  task automatic t_reset;
    chk("R1 fill", fill, 0); chk("R1 ovf", ovf, 0); chk("R1 load", load, 0);
  endtask

  task automatic t_fill_order;
    restart(); gap = 0;
    for (int i = 0; i < 5; i++) begin
      wr(8'hA0 + 8'(i));
      chk("R2 fill", fill, i + 1);
    end
    chk("R4 no load while shifter busy", n_log, 0);
    hold = 0;
    repeat (40) @(negedge clk);
    chk("R2 loads", n_log, 5);
    for (int i = 0; i < 5; i++) chk("R2 order", log_data[i], 8'hA0 + i);
    chk("R4 fill drained", fill, 0);
  endtask

  task automatic t_overflow;
    restart();
    for (int i = 0; i < 16; i++) wr(8'(i * 3));
    chk("R3 full", fill, 16);
    chk("R3 no ovf yet", ovf, 0);
    wr(8'hEE);
    chk("R3 ovf pulse", ovf, 1);
    chk("R3 fill held", fill, 16);
    @(negedge clk);
    chk("R3 ovf one cycle", ovf, 0);
    hold = 0;
    repeat (120) @(negedge clk);
    chk("R3 loads", n_log, 16);
    chk("R3 last kept byte", log_data[15], 45);
  endtask

  task automatic t_irq;
    restart(); trig = 4;
    for (int i = 0; i <= 6; i++) begin
      chk("R7 irq", irq, (i <= 4) ? 1 : 0);
      wr(8'(i));
    end
    trig = 0;
    restart();
    chk("R7 irq empty trig0", irq, 1);
    wr(8'h11);
    chk("R7 irq one trig0", irq, 0);
  endtask

  task automatic t_gap;
    restart(); gap = 5; tick_en = 1;
    for (int i = 0; i < 3; i++) wr(8'h50 + 8'(i));
    hold = 0;
    repeat (150) @(negedge clk);
    chk("R5 loads", n_log, 3);
    chk("R5 gap ticks 1", log_ticks[1], 5);
    chk("R5 gap ticks 2", log_ticks[2], 5);
    chk("R5 order", log_data[2], 8'h52);
    tick_en = 0; gap = 0;
  endtask

  task automatic t_zero_gap;
    restart(); gap = 0;
    for (int i = 0; i < 4; i++) wr(8'h60 + 8'(i));
    hold = 0;
    repeat (40) @(negedge clk);
    chk("R6 loads", n_log, 4);
    for (int i = 1; i < 4; i++) chk("R6 back to back", log_cyc[i], 4);
  endtask

  task automatic t_clear;
    restart();
    for (int i = 0; i < 3; i++) wr(8'h70 + 8'(i));
    chk("R8 pre fill", fill, 3);
    @(negedge clk); fifo_run = 0;
    @(negedge clk);
    chk("R8 cleared", fill, 0);
    wr(8'h77);
    chk("R8 write ignored", fill, 0);
    hold = 0; repeat (10) @(negedge clk);
    chk("R8 no load", n_log, 0);
    hold = 1; fifo_run = 1;
    wr(8'h5A);
    hold = 0; repeat (10) @(negedge clk);
    chk("R8 restart loads", n_log, 1);
    chk("R8 restart byte", log_data[0], 8'h5A);
  endtask

  task automatic t_bypass;
    restart();
    wr(8'h21); wr(8'h22);
    @(negedge clk); fifo_en = 0;
    @(negedge clk);
    chk("R9 fill cleared", fill, 0);
    chk("R9 irq off", irq, 0);
    wr_valid = 1; wr_data = 8'h3C; #1;
    chk("R9 direct load", load, 1);
    chk("R9 direct data", load_data, 8'h3C);
    @(negedge clk); wr_valid = 0; #1;
    chk("R9 strobe follows", load, 0);
    chk("R9 fill stays", fill, 0);
    fifo_en = 1; n_log = 0; hold = 0;
    repeat (10) @(negedge clk);
    chk("R9 old bytes dropped", n_log, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1; fifo_en = 1; fifo_run = 1;
    @(negedge clk);
    t_reset();
    t_fill_order();
    t_overflow();
    t_irq();
    t_gap();
    t_zero_gap();
    t_clear();
    t_bypass();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule